// File: doc/BRIEF.md
# PCI Interrupt Line Steering Unit

This block steers four PCI interrupt request levels onto sixteen ISA interrupt lines that feed a legacy interrupt controller. Each PCI line owns one byte-wide steering register in configuration space. The register selects the ISA line that the PCI line drives, or it parks the PCI line so that it drives nothing. More than one PCI line may be steered to the same ISA line. That line is then asserted while any one of them is asserted.

Legacy ISA devices share the same sixteen lines. Each one has its own request input, which is ORed straight into the matching output. The outputs are purely combinational in the PCI levels, the legacy requests and the steering registers. A configuration write changes a steering register on the clock edge that samples the write strobe. The outputs move at that same edge, with no further delay.

Top module: `irq_steer`

## Requirements
- R1: Four steering registers sit at configuration byte addresses 0x60, 0x61, 0x62 and 0x63, for PCI lines 0 to 3 in that order. A write with `cfg_we` high stores all 8 bits of `cfg_wdata` at the clock edge that samples the strobe. `cfg_rdata` returns the stored byte of the addressed register combinationally, with no side effects.
- R2: A clock edge with `rst_n` low loads every steering register with 0x80. After that edge, `irq_out` equals `legacy_req` whatever the PCI levels are.
- R3: A steering value below 16 routes the PCI line to ISA line number value[3:0]. While that PCI level is high, the ISA line is high. Line 0 and line 15 are both reachable.
- R4: A steering value of 16 or more disables the route. This is the case when any of bits 7 to 4 is set, for example 0x10, 0x1A or 0x83. A disabled PCI line drives no ISA line.
- R5: When several PCI lines are routed to one ISA line, that line is the OR of their levels.
- R6: Each `irq_out[i]` is also ORed with `legacy_req[i]`.
- R7: Rewriting a steering register moves the line's contribution to the new target at the same clock edge. The old ISA line drops it at that edge.
- R8: Configuration addresses outside 0x60 to 0x63 read as 0x00. Writes to them leave every steering register unchanged.
- R9: `irq_out` follows a change of `pci_lvl` or `legacy_req` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| pci_lvl | input | 4 | PCI interrupt request levels, lines 0 to 3 |
| legacy_req | input | 16 | Direct ISA device requests |
| irq_out | output | 16 | ISA interrupt line levels |

## Verification
The steering function is tried with four kinds of input pattern:
- **Each PCI line steered alone**, including targets 0 and 15. This separates the correct line from a neighbouring or mis-decoded one.
- **Two PCI lines on one ISA line**, toggled one at a time. This separates an OR from a last-writer-wins mux.
- **Out-of-range values 0x10, 0x1A and 0x83.** These show whether all of the upper nibble gates the route or only bit 7.
- **Walking legacy requests, and a route rewritten while its PCI line is active.** These expose a missing merge and a stale contribution on the old line.

// File: rtl/irq_steer_pkg.sv
// Package: shared byte type and the reset value of a steering register.
// Assumes configuration space is byte addressed with 8-bit addresses.
package irq_steer_pkg;
    localparam int CFG_W = 8;
    typedef logic [CFG_W-1:0] cfg_byte_t;
    localparam cfg_byte_t ROUTE_RST = 8'h80;
endpackage

// File: rtl/irq_route_reg.sv
// One steering register: it loads on a write strobe that matches its address
// and resets synchronously. Assumes one byte write per cycle at most.
module irq_route_reg
    import irq_steer_pkg::*;
#(
    parameter cfg_byte_t ADDR    = 8'h60,
    parameter cfg_byte_t RST_VAL = ROUTE_RST
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  cfg_byte_t addr,
    input  cfg_byte_t wdata,
    output cfg_byte_t q
);
    // Hold the route byte; reset it, or load it on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (we && addr == ADDR)
            q <= wdata;
    end
endmodule

// File: rtl/irq_route_dec.sv
// Turns one steering byte and its PCI level into a one-hot request vector.
// Assumes NUM_IRQ is a power of two; any bit above the select field disables.
module irq_route_dec
    import irq_steer_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int SEL_W  = $clog2(NUM_IRQ)
) (
    input  cfg_byte_t            route,
    input  logic                 lvl,
    output logic [NUM_IRQ-1:0]   hit
);
    logic             enabled;
    logic [SEL_W-1:0] sel;

    // Split the byte into an enable and a line number.
    always_comb begin
        enabled = ((route >> SEL_W) == '0);
        sel     = route[SEL_W-1:0];
    end

    // Drive the selected line only while the route is enabled and the level is high.
    always_comb begin
        hit = '0;
        if (enabled && lvl)
            hit[sel] = 1'b1;
    end
endmodule

// File: rtl/irq_merge.sv
// ORs the request vectors of all PCI lines together with the legacy requests.
// Assumes level-sensitive lines, so a plain OR is the correct merge.
module irq_merge #(
    parameter int NUM_SRC = 4,
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_SRC-1:0][NUM_IRQ-1:0] hits,
    input  logic [NUM_IRQ-1:0]              legacy,
    output logic [NUM_IRQ-1:0]              irq
);
    // Fold every source vector into the legacy requests.
    always_comb begin
        irq = legacy;
        for (int s = 0; s < NUM_SRC; s++)
            irq = irq | hits[s];
    end
endmodule

// File: rtl/irq_steer.sv
// Top level: NUM_SRC steering registers at consecutive addresses from
// BASE_ADDR, their decoders, the output merge and the read-back mux.
// Assumes BASE_ADDR + NUM_SRC fits in the 8-bit configuration space.
module irq_steer
    import irq_steer_pkg::*;
#(
    parameter int        NUM_SRC   = 4,
    parameter int        NUM_IRQ   = 16,
    parameter cfg_byte_t BASE_ADDR = 8'h60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic [NUM_SRC-1:0]   pci_lvl,
    input  logic [NUM_IRQ-1:0]   legacy_req,
    output logic [NUM_IRQ-1:0]   irq_out
);
    logic [NUM_SRC-1:0][CFG_W-1:0]   route_q;
    logic [NUM_SRC-1:0][NUM_IRQ-1:0] hits;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        irq_route_reg #(
            .ADDR    (8'(BASE_ADDR + gi)),
            .RST_VAL (ROUTE_RST)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we),
            .addr  (cfg_addr),
            .wdata (cfg_wdata),
            .q     (route_q[gi])
        );

        irq_route_dec #(.NUM_IRQ(NUM_IRQ)) u_dec (
            .route (route_q[gi]),
            .lvl   (pci_lvl[gi]),
            .hit   (hits[gi])
        );
    end

    irq_merge #(.NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ)) u_merge (
        .hits   (hits),
        .legacy (legacy_req),
        .irq    (irq_out)
    );

    // Return the addressed steering byte, or zero outside the register window.
    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_SRC; k++)
            if (cfg_addr == 8'(BASE_ADDR + k))
                cfg_rdata = route_q[k];
    end
endmodule

// File: rtl/irq_steer_chk.sv
// Checker for irq_steer: properties on the steering registers and the outputs.
// Attached through the bind statement below; it observes and drives nothing.
module irq_steer_chk #(
    parameter int         NUM_SRC   = 4,
    parameter int         NUM_IRQ   = 16,
    parameter logic [7:0] BASE_ADDR = 8'h60,
    localparam int        SEL_W     = $clog2(NUM_IRQ)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_we,
    input logic [7:0]                    cfg_addr,
    input logic [7:0]                    cfg_wdata,
    input logic [NUM_SRC-1:0]            pci_lvl,
    input logic [NUM_IRQ-1:0]            legacy_req,
    input logic [NUM_IRQ-1:0]            irq_out,
    input logic [NUM_SRC-1:0][7:0]       route_q
);
    logic prev_rst_low;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) prev_rst_low <= !rst_n;

    assert_legacy_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & legacy_req) == legacy_req);

    assert_idle_pci_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_lvl == '0) |-> (irq_out == legacy_req));

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        assert_reset_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
            prev_rst_low |-> (route_q[k] == 8'h80));

        assert_write_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == 8'(BASE_ADDR + k)) |=> (route_q[k] == $past(cfg_wdata)));

        assert_other_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == 8'(BASE_ADDR + k)) |=> $stable(route_q[k]));

        assert_route_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (pci_lvl[k] && (route_q[k] >> SEL_W) == '0) |-> irq_out[route_q[k][SEL_W-1:0]]);
    end
endmodule

bind irq_steer irq_steer_chk #(
    .NUM_SRC   (NUM_SRC),
    .NUM_IRQ   (NUM_IRQ),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .pci_lvl    (pci_lvl),
    .legacy_req (legacy_req),
    .irq_out    (irq_out),
    .route_q    (route_q)
);

// File: tb/irq_steer_test.sv
// Bench: a behavioural model of the four steering bytes, compared with the
// outputs and the read-back data at every falling edge.
module irq_steer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_lvl = 4'h0;
    logic [15:0] legacy_req = 16'h0;
    logic [15:0] irq_out;

    int    errors = 0;
    int    checks = 0;
    bit    started = 0;
    bit    done = 0;
    string phase = "R2";
    int    model [4];

    irq_steer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_lvl(pci_lvl),
        .legacy_req(legacy_req), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    // Model update at each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) model[k] = 8'h80;
        end else if (cfg_we && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) begin
            model[cfg_addr - 8'h60] = cfg_wdata;
        end
    end

    function automatic logic [15:0] exp_irq();
        logic [15:0] e = legacy_req;
        for (int k = 0; k < 4; k++)
            if (model[k] < 16 && pci_lvl[k]) e[model[k]] = 1'b1;
        return e;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (cfg_addr >= 8'h60 && cfg_addr <= 8'h63) return 8'(model[cfg_addr - 8'h60]);
        return 8'h00;
    endfunction

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (irq_out !== exp_irq()) begin
                errors++;
                $display("FAIL %s irq_out got %h expected %h", phase, irq_out, exp_irq());
            end
            checks++;
            if (cfg_rdata !== exp_rd()) begin
                errors++;
                $display("FAIL %s cfg_rdata at %h got %h expected %h", phase, cfg_addr, cfg_rdata, exp_rd());
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        #1;
        step(3);
        rst_n = 1'b1;
        // R2: reset values and disabled routes
        phase = "R2";
        pci_lvl = 4'hF;
        for (int a = 8'h60; a <= 8'h63; a++) begin cfg_addr = 8'(a); step(); end
        // R1: write and read back
        phase = "R1";
        wr(8'h60, 8'h05); step();
        wr(8'h63, 8'h6C); step();
        // R3: single route, targets 5, 0, 15
        phase = "R3";
        pci_lvl = 4'h1; step(2);
        pci_lvl = 4'h0; step();
        wr(8'h61, 8'h00); pci_lvl = 4'h2; step(2);
        wr(8'h62, 8'h0F); pci_lvl = 4'h4; step(2);
        // R9: level changes reach the output in the same cycle
        phase = "R9";
        for (int v = 0; v < 8; v++) begin pci_lvl = 4'(v); step(); end
        // R5: two lines share IRQ 5
        phase = "R5";
        wr(8'h61, 8'h05);
        pci_lvl = 4'h1; step(); pci_lvl = 4'h3; step();
        pci_lvl = 4'h2; step(); pci_lvl = 4'h0; step();
        // R4: out-of-range values disable
        phase = "R4";
        wr(8'h62, 8'h10); wr(8'h63, 8'h1A); pci_lvl = 4'hC; step(2);
        wr(8'h62, 8'h83); wr(8'h63, 8'h80); pci_lvl = 4'hF; step(2);
        // R7: rewrite a route while its line is active
        phase = "R7";
        pci_lvl = 4'h1; wr(8'h61, 8'h80); step();
        wr(8'h60, 8'h0B); step(); wr(8'h60, 8'h03); step();
        // R6: walking legacy requests
        phase = "R6";
        for (int i = 0; i < 16; i++) begin legacy_req = 16'(1 << i); step(); end
        legacy_req = 16'hA5A5; step(); legacy_req = 16'h0; step();
        // R8: addresses outside the window
        phase = "R8";
        wr(8'h64, 8'h02); wr(8'h5F, 8'h04); wr(8'h00, 8'h01);
        cfg_addr = 8'h64; step(); cfg_addr = 8'hFF; step(); cfg_addr = 8'h60; step();
        // R2: reset mid-run restores 0x80
        phase = "R2";
        rst_n = 1'b0; step(); rst_n = 1'b1; pci_lvl = 4'hF;
        for (int a = 8'h60; a <= 8'h63; a++) begin cfg_addr = 8'(a); step(); end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        done = 1'b1;
        $display("FAIL watchdog expired got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule